// File: doc/BRIEF.md
# Serial EEPROM Device Model (three-wire command, one-wire reply)

This block is a synthesizable stand-in for a small serial EEPROM that stores 16-bit words. A host talks to it over four wires: a select line that frames each command, a serial clock, a serial data input and a serial data output. Each command is a start bit of 1, a 2-bit opcode, an address field sent MSB first, and, for the two writing commands, 16 data bits sent MSB first. The address field is 6 bits by default in the bench and 8 bits by default in the RTL, chosen by a parameter. The storage array is made of flip-flops, and all words reset to all ones.

The select, clock and data inputs are synchronised into the system clock, and edges are found there, so the serial clock must be much slower than the system clock. Programming commands are locked after reset. An unlock command opens them and a lock command closes them again. A programming command takes effect when select falls at the end of a complete frame. It then starts a busy period of a set number of system clocks. While select is high and no new start bit has come in, the output line shows this status: low while busy, high once done.

Top module: `ser_eeprom_dev`

## Requirements
- R1: After reset the programming lock is closed, every word reads 16'hFFFF, and dout_o is 0. A write sent before any unlock command changes nothing.
- R2: A read (start 1, opcode 2'b10, address MSB first) drives 0 on dout_o after the rising serial clock edge that carries the last address bit. Each later rising edge presents the next bit of the addressed word, MSB first.
- R3: When unlocked, a write (opcode 2'b01) followed by 16 data bits MSB first stores the data at the address once select falls.
- R4: When unlocked, an erase (opcode 2'b11) sets the addressed word to 16'hFFFF.
- R5: Opcode 2'b00 uses the top two address bits as a sub-command. 2'b11 unlocks programming and 2'b00 locks it again. The remaining address bits are ignored. While locked, no word changes.
- R6: When unlocked, sub-command 2'b10 sets every word to 16'hFFFF.
- R7: When unlocked, sub-command 2'b01 followed by 16 data bits writes that data into every word.
- R8: A low select returns the device to idle at any point and holds dout_o at 0. A programming frame cut short before its last bit changes nothing and starts no busy period.
- R9: An accepted programming command starts a busy period of BUSY_CYCLES system clocks from the select fall. After select rises again, dout_o is 0 while busy and 1 once done, until the next start bit.
- R10: While idle with select high, rising clock edges with data 0 before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Command select, high for the length of a frame |
| sck_i | input | 1 | Serial clock; bits are taken on its rising edge |
| din_i | input | 1 | Serial command, address and data input |
| dout_o | output | 1 | Serial read data, or busy/ready status |

## Verification
The embedded properties watch several things on every cycle. They check that a low select forces the frame logic to idle and the output low, and that a read always opens with a zero bit. They check that no word write reaches the array while the lock is closed, and that the busy counter never exceeds its limit and counts down one step per clock. A busy device must show low status. The bench scenarios are the only way to show end-to-end behaviour: actual word contents after write, erase, fill and wipe, the MSB-first bit order, the lock and unlock sequence, aborted frames, ignored leading zeros, and the moment status turns ready. A reference memory model in the bench covers these, through directed boundary addresses and seeded random command mixes.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

   // Main opcode, the two bits after the start bit.
   typedef enum logic [1:0] {
      OPC_EXT   = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_ERASE = 2'b11
   } opc_e;

   // Sub-command carried in the top two address bits when the opcode is OPC_EXT.
   typedef enum logic [1:0] {
      XC_LOCK   = 2'b00,
      XC_FILL   = 2'b01,
      XC_WIPE   = 2'b10,
      XC_UNLOCK = 2'b11
   } xcmd_e;

   // Programming action handed to the storage array.
   typedef enum logic [1:0] {
      PK_WORD  = 2'd0,
      PK_CLEAR = 2'd1,
      PK_FILL  = 2'd2,
      PK_WIPE  = 2'd3
   } prog_kind_e;

   typedef enum logic [2:0] {
      FS_IDLE  = 3'd0,
      FS_OPC   = 3'd1,
      FS_ADDR  = 3'd2,
      FS_DATA  = 3'd3,
      FS_RDLD  = 3'd4,
      FS_RDOUT = 3'd5,
      FS_HOLD  = 3'd6
   } frame_st_e;

endpackage

// File: rtl/ser_eeprom_sync.sv
module ser_eeprom_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic din_i,
   output logic cs_s_o,
   output logic cs_fall_o,
   output logic sck_rise_o,
   output logic din_s_o
);

   logic [STAGES-1:0] cs_pipe, sck_pipe, din_pipe;
   logic              cs_prev, sck_prev;

   initial begin
      assert (STAGES >= 2) else $error("ser_eeprom_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_pipe  <= '0;
         sck_pipe <= '0;
         din_pipe <= '0;
         cs_prev  <= 1'b0;
         sck_prev <= 1'b0;
      end else begin
         cs_pipe  <= {cs_pipe[STAGES-2:0],  cs_i};
         sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
         din_pipe <= {din_pipe[STAGES-2:0], din_i};
         cs_prev  <= cs_pipe[STAGES-1];
         sck_prev <= sck_pipe[STAGES-1];
      end
   end

   assign cs_s_o     = cs_pipe[STAGES-1];
   assign din_s_o    = din_pipe[STAGES-1];
   assign cs_fall_o  = cs_prev & ~cs_pipe[STAGES-1];
   assign sck_rise_o = sck_pipe[STAGES-1] & ~sck_prev;

endmodule

// File: rtl/ser_eeprom_frame.sv
module ser_eeprom_frame
   import ser_eeprom_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          cs_fall,
   input  logic          sck_rise,
   input  logic          din_s,
   input  logic          busy_i,
   input  logic [DW-1:0] rd_word_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          rd_drive_o,
   output logic          rd_bit_o,
   output logic          start_o,
   output logic          wen_o,
   output logic          prog_o,
   output prog_kind_e    prog_kind_o,
   output logic [AW-1:0] prog_addr_o,
   output logic [DW-1:0] prog_data_o
);

   localparam int CNT_W = $clog2(DW);

   frame_st_e      state_q;
   logic [1:0]     op_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  data_q;
   logic [DW-1:0]  rd_sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic           rd_bit_q;
   logic           wen_q;
   logic           armed_q;
   prog_kind_e     kind_q;

   logic [AW-1:0]  addr_nx;
   logic [1:0]     ext_w;

   initial begin
      assert (DW >= AW && DW >= 2) else $error("ser_eeprom_frame: DW must cover AW");
   end

   assign addr_nx = {addr_q[AW-2:0], din_s};
   assign ext_w   = addr_nx[AW-1:AW-2];
   assign start_o = cs_s && (state_q == FS_IDLE) && sck_rise && din_s && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FS_IDLE;
         op_q     <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         rd_sh_q  <= '0;
         cnt_q    <= '0;
         rd_bit_q <= 1'b0;
         wen_q    <= 1'b0;
         armed_q  <= 1'b0;
         kind_q   <= PK_WORD;
      end else if (!cs_s) begin
         state_q  <= FS_IDLE;
         armed_q  <= 1'b0;
         rd_bit_q <= 1'b0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (start_o) begin
                  state_q <= FS_OPC;
                  cnt_q   <= '0;
               end
            end
            FS_OPC: begin
               if (sck_rise) begin
                  op_q <= {op_q[0], din_s};
                  if (cnt_q == CNT_W'(1)) begin
                     state_q <= FS_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FS_ADDR: begin
               if (sck_rise) begin
                  addr_q <= addr_nx;
                  if (cnt_q == CNT_W'(AW-1)) begin
                     cnt_q <= '0;
                     unique case (opc_e'(op_q))
                        OPC_READ: begin
                           state_q  <= FS_RDLD;
                           rd_bit_q <= 1'b0;
                        end
                        OPC_WRITE: begin
                           state_q <= FS_DATA;
                           kind_q  <= PK_WORD;
                        end
                        OPC_ERASE: begin
                           state_q <= FS_HOLD;
                           kind_q  <= PK_CLEAR;
                           armed_q <= 1'b1;
                        end
                        default: begin
                           unique case (xcmd_e'(ext_w))
                              XC_UNLOCK: begin
                                 wen_q   <= 1'b1;
                                 state_q <= FS_HOLD;
                              end
                              XC_LOCK: begin
                                 wen_q   <= 1'b0;
                                 state_q <= FS_HOLD;
                              end
                              XC_WIPE: begin
                                 kind_q  <= PK_WIPE;
                                 armed_q <= 1'b1;
                                 state_q <= FS_HOLD;
                              end
                              default: begin
                                 kind_q  <= PK_FILL;
                                 state_q <= FS_DATA;
                              end
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FS_DATA: begin
               if (sck_rise) begin
                  data_q <= {data_q[DW-2:0], din_s};
                  if (cnt_q == CNT_W'(DW-1)) begin
                     state_q <= FS_HOLD;
                     armed_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            FS_RDLD: begin
               rd_sh_q <= rd_word_i;
               state_q <= FS_RDOUT;
            end
            FS_RDOUT: begin
               if (sck_rise) begin
                  rd_bit_q <= rd_sh_q[DW-1];
                  rd_sh_q  <= {rd_sh_q[DW-2:0], 1'b0};
               end
            end
            default: ;
         endcase
      end
   end

   assign rd_addr_o   = addr_q;
   assign rd_drive_o  = (state_q == FS_RDLD) || (state_q == FS_RDOUT);
   assign rd_bit_o    = rd_bit_q;
   assign wen_o       = wen_q;
   assign prog_o      = cs_fall && armed_q && wen_q;
   assign prog_kind_o = kind_q;
   assign prog_addr_o = addr_q;
   assign prog_data_o = data_q;

   AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (state_q == FS_IDLE)); // R8

   AST_READ_LEADS_WITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_drive_o) |-> !rd_bit_o); // R2

   AST_NO_ARM_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_IDLE) |-> !armed_q); // R8

endmodule

// File: rtl/ser_eeprom_array.sv
module ser_eeprom_array
   import ser_eeprom_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_i,
   input  logic          wen_i,
   input  prog_kind_e    prog_kind_i,
   input  logic [AW-1:0] prog_addr_i,
   input  logic [DW-1:0] prog_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_word_o
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] cells [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      logic [DW-1:0] cell_q;
      logic          hit;

      assign hit = (prog_addr_i == AW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '1;
         end else if (prog_i) begin
            unique case (prog_kind_i)
               PK_WORD:  if (hit) cell_q <= prog_data_i;
               PK_CLEAR: if (hit) cell_q <= '1;
               PK_FILL:  cell_q <= prog_data_i;
               default:  cell_q <= '1;
            endcase
         end
      end

      assign cells[gi] = cell_q;
   end

   assign rd_word_o = cells[rd_addr_i];

   AST_PROG_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      prog_i |-> wen_i); // R5

   AST_CLEAR_GIVES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_i && prog_kind_i == PK_CLEAR) |=> (cells[$past(prog_addr_i)] == '1)); // R4

endmodule

// File: rtl/ser_eeprom_busy.sv
module ser_eeprom_busy #(
   parameter int BUSY_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   localparam int CW = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (BUSY_CYCLES >= 1) else $error("ser_eeprom_busy: BUSY_CYCLES must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CW'(BUSY_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   AST_BUSY_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(BUSY_CYCLES)); // R9

   AST_BUSY_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/ser_eeprom_dev.sv
module ser_eeprom_dev
   import ser_eeprom_pkg::*;
#(
   parameter int ADDR_BITS   = 8,
   parameter int DATA_BITS   = 16,
   parameter int BUSY_CYCLES = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic din_i,
   output logic dout_o
);

   logic                 cs_s, cs_fall, sck_rise, din_s;
   logic                 busy_w, start_w, wen_w, prog_w;
   logic                 rd_drive_w, rd_bit_w;
   logic [ADDR_BITS-1:0] rd_addr_w, prog_addr_w;
   logic [DATA_BITS-1:0] rd_word_w, prog_data_w;
   prog_kind_e           prog_kind_w;
   logic                 stat_q;

   initial begin
      assert (ADDR_BITS == 6 || ADDR_BITS == 8)
         else $error("ser_eeprom_dev: ADDR_BITS must be 6 or 8");
      assert (DATA_BITS == 16)
         else $error("ser_eeprom_dev: DATA_BITS must be 16");
   end

   ser_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_i),
      .sck_i      (sck_i),
      .din_i      (din_i),
      .cs_s_o     (cs_s),
      .cs_fall_o  (cs_fall),
      .sck_rise_o (sck_rise),
      .din_s_o    (din_s)
   );

   ser_eeprom_frame #(.AW(ADDR_BITS), .DW(DATA_BITS)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_s        (cs_s),
      .cs_fall     (cs_fall),
      .sck_rise    (sck_rise),
      .din_s       (din_s),
      .busy_i      (busy_w),
      .rd_word_i   (rd_word_w),
      .rd_addr_o   (rd_addr_w),
      .rd_drive_o  (rd_drive_w),
      .rd_bit_o    (rd_bit_w),
      .start_o     (start_w),
      .wen_o       (wen_w),
      .prog_o      (prog_w),
      .prog_kind_o (prog_kind_w),
      .prog_addr_o (prog_addr_w),
      .prog_data_o (prog_data_w)
   );

   ser_eeprom_array #(.AW(ADDR_BITS), .DW(DATA_BITS)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_i      (prog_w),
      .wen_i       (wen_w),
      .prog_kind_i (prog_kind_w),
      .prog_addr_i (prog_addr_w),
      .prog_data_i (prog_data_w),
      .rd_addr_i   (rd_addr_w),
      .rd_word_o   (rd_word_w)
   );

   ser_eeprom_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (prog_w),
      .busy_o (busy_w)
   );

   // Status mode: armed by an accepted programming command, left on the next start bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= 1'b0;
      else if (prog_w)  stat_q <= 1'b1;
      else if (start_w) stat_q <= 1'b0;
   end

   assign dout_o = cs_s & (rd_drive_w ? rd_bit_w : (stat_q & ~busy_w));

   AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |-> !dout_o); // R8

   AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && !rd_drive_w) |-> !dout_o); // R9

   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_w) |-> !rd_drive_w); // R9

endmodule

// File: tb/test_ser_eeprom_dev.sv
module test_ser_eeprom_dev;

   localparam int AW    = 6;
   localparam int WORDS = 1 << AW;
   localparam int BUSY  = 60;
   localparam int H     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, din = 1'b0;
   logic dout;

   int n_checks = 0;
   int n_fails  = 0;

   logic [15:0] mem_m [WORDS];
   logic        wen_m;

   always #10 clk = ~clk;

   ser_eeprom_dev #(.ADDR_BITS(AW), .DATA_BITS(16), .BUSY_CYCLES(BUSY)) i_ser_eeprom_dev (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_i   (cs),
      .sck_i  (sck),
      .din_i  (din),
      .dout_o (dout)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model_read(input int a);
      return mem_m[a];
   endfunction

   task automatic ser_bit(input logic b, output logic s);
      din = b;
      wait_clk(H);
      sck = 1'b1;
      wait_clk(H);
      s = dout;
      sck = 1'b0;
   endtask

   task automatic end_frame();
      wait_clk(H);
      cs = 1'b0;
      din = 1'b0;
      wait_clk(2 * H);
   endtask

   task automatic do_read(input int a, input int lead0, output logic dummy, output logic [15:0] w);
      logic s;
      cs = 1'b1;
      wait_clk(H);
      for (int i = 0; i < lead0; i++) ser_bit(1'b0, s);
      ser_bit(1'b1, s);
      ser_bit(1'b1, s);
      ser_bit(1'b0, s);
      for (int i = AW - 1; i >= 0; i--) ser_bit(a[i], s);
      dummy = s;
      for (int i = 15; i >= 0; i--) begin
         ser_bit(1'b0, s);
         w[i] = s;
      end
      end_frame();
   endtask

   // Sends start, opcode, address field and the first ndata data bits, then drops select.
   task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] af,
                           input logic [15:0] data, input int ndata);
      logic s;
      cs = 1'b1;
      wait_clk(H);
      ser_bit(1'b1, s);
      ser_bit(op[1], s);
      ser_bit(op[0], s);
      for (int i = AW - 1; i >= 0; i--) ser_bit(af[i], s);
      for (int i = 0; i < ndata; i++) ser_bit(data[15 - i], s);
      end_frame();
   endtask

   function automatic logic [AW-1:0] ext_field(input logic [1:0] sub);
      return {sub, {(AW - 2){1'b0}}};
   endfunction

   task automatic check_busy_ready(input string req);
      cs = 1'b1;
      wait_clk(4);
      check({req, " busy status low"}, {15'd0, dout}, 16'd0);
      wait_clk(BUSY + 20);
      check({req, " ready status high"}, {15'd0, dout}, 16'd1);
      cs = 1'b0;
      wait_clk(2 * H);
   endtask

   task automatic read_check(input string req, input int a, input int lead0);
      logic        dm;
      logic [15:0] w;
      do_read(a, lead0, dm, w);
      check({req, " dummy bit"}, {15'd0, dm}, 16'd0);
      check({req, " word"}, w, model_read(a));
   endtask

   task automatic unlock();
      send_cmd(2'b00, ext_field(2'b11), 16'h0, 0);
      wen_m = 1'b1;
   endtask

   task automatic lock();
      send_cmd(2'b00, ext_field(2'b00), 16'h0, 0);
      wen_m = 1'b0;
   endtask

   task automatic prog_write(input int a, input logic [15:0] d, input logic chk_busy);
      send_cmd(2'b01, AW'(a), d, 16);
      if (wen_m) begin
         mem_m[a] = d;
         if (chk_busy) check_busy_ready("R9 write");
         else wait_clk(BUSY + 10);
      end
   endtask

   task automatic prog_erase(input int a);
      send_cmd(2'b11, AW'(a), 16'h0, 0);
      if (wen_m) begin
         mem_m[a] = 16'hFFFF;
         wait_clk(BUSY + 10);
      end
   endtask

   initial begin : watchdog
      wait_clk(190000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      logic s;
      for (int i = 0; i < WORDS; i++) mem_m[i] = 16'hFFFF;
      wen_m = 1'b0;
      void'($urandom(32'h5EED_0A17));

      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1: reset state
      check("R1 dout after reset", {15'd0, dout}, 16'd0);
      read_check("R1 R2 erased after reset", 5, 0);

      // R1: write before unlock has no effect
      prog_write(5, 16'h1234, 1'b0);
      read_check("R1 locked write ignored", 5, 0);

      // R3 / R9 / R10
      unlock();
      prog_write(5, 16'hA5C3, 1'b1);
      read_check("R3 R10 write with leading zeros", 5, 2);

      // R4
      send_cmd(2'b11, AW'(5), 16'h0, 0);
      mem_m[5] = 16'hFFFF;
      check_busy_ready("R9 erase");
      read_check("R4 erase", 5, 0);

      // R3 boundary addresses
      prog_write(0, 16'h8001, 1'b0);
      prog_write(WORDS - 1, 16'h7FFE, 1'b0);
      read_check("R3 lowest address", 0, 0);
      read_check("R3 highest address", WORDS - 1, 0);

      // R8: aborted write, no busy status afterwards
      cs = 1'b1;
      wait_clk(H);
      ser_bit(1'b1, s); ser_bit(1'b0, s); ser_bit(1'b1, s);
      for (int i = AW - 1; i >= 0; i--) ser_bit(1'b1 ^ i[0], s);
      for (int i = 0; i < 8; i++) ser_bit(1'b1, s);
      end_frame();
      cs = 1'b1;
      wait_clk(10);
      check("R8 no status after abort", {15'd0, dout}, 16'd0);
      cs = 1'b0;
      wait_clk(2 * H);
      read_check("R8 aborted write unchanged", 21, 0);

      // R7
      send_cmd(2'b00, ext_field(2'b01), 16'h3C0F, 16);
      for (int i = 0; i < WORDS; i++) mem_m[i] = 16'h3C0F;
      check_busy_ready("R9 write-all");
      read_check("R7 write-all low", 0, 0);
      read_check("R7 write-all mid", 17, 0);
      read_check("R7 write-all high", WORDS - 1, 0);

      // R6
      send_cmd(2'b00, ext_field(2'b10), 16'h0, 0);
      for (int i = 0; i < WORDS; i++) mem_m[i] = 16'hFFFF;
      check_busy_ready("R9 erase-all");
      read_check("R6 erase-all low", 0, 0);
      read_check("R6 erase-all mid", 40, 0);
      read_check("R6 erase-all high", WORDS - 1, 0);

      // R5: lock closes programming again
      lock();
      prog_write(9, 16'h1111, 1'b0);
      read_check("R5 locked after disable", 9, 0);

      // Random command mix against the model
      for (int n = 0; n < 30; n++) begin
         int          kind;
         int          a;
         logic [15:0] d;
         kind = int'($urandom % 5);
         a    = int'($urandom % WORDS);
         d    = 16'($urandom);
         case (kind)
            0: unlock();
            1: lock();
            2: prog_write(a, d, 1'b0);
            3: prog_erase(a);
            default: read_check("R2 R3 R5 random read", a, int'($urandom % 3));
         endcase
      end
      for (int i = 0; i < 8; i++) read_check("R3 R4 final sweep", i * 9, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule